// File: doc/BRIEF.md
# Acquire-Ordered Signed Word Load Unit

This block executes exactly one kind of instruction: a 32-bit encoded load that reads a 4-byte word and sign-extends it to 64 bits. The word comes from memory with acquire ordering, at an address formed from a base register plus a small signed byte offset. The unit accepts an instruction word over a valid/ready port and decodes it. It reads the base through a register-file read port, or takes the stack-pointer input when the base index is 31. It checks stack-pointer alignment and issues a single read request marked as acquire. It waits for the response and writes the sign-extended word back through a register-file write port.

Both memory channels follow valid/ready rules. The unit raises its request valid and holds the address, size and qualifier stable until the memory raises ready. It raises response ready only while it waits for data, and a response is taken on the edge where both signals are high. While a load is in flight the instruction port shows not-ready, so an upstream stage stalls there. The unit does not drop or queue work. A one-cycle done pulse ends every instruction, whether it wrote back or faulted. The undefined-instruction flag or the alignment-fault flag tells the two fault outcomes apart.

Top module: `acq_sword_load_unit`

## Requirements
- R1: An instruction word matches only when bits [31:21] are 10011001100 and bits [11:10] are 00. Any other word ends with done and the undefined flag high, with no memory request and no register write.
- R2: The feature-enable input is sampled on the edge that accepts the instruction. If it is low there, the instruction is reported as undefined, with no memory request and no register write.
- R3: The request address is the base plus the sign-extended 9-bit field in bits [20:12], wrapping modulo 2^64. The offset therefore ranges from -256 to +255.
- R4: The base index is bits [9:5] and drives the register read index. The value 31 selects the stack-pointer input in place of the register-file data.
- R5: With base index 31, a stack pointer whose low 4 bits are not all zero ends the instruction with done and the alignment-fault flag, with no request and no write. A register base is never checked for alignment. An undefined encoding is never reported as an alignment fault.
- R6: Each request carries size code 2 (log2 of 4 bytes) and the acquire qualifier high. Its valid, address, size and qualifier stay stable until ready is seen.
- R7: The write-back data is the low 32 bits of the response, sign-extended to 64 bits. Upper response bits are ignored. The write index is bits [4:0].
- R8: Done is high for exactly one cycle per instruction. The instruction port is not ready from acceptance until done.
- R9: The request appears one cycle after acceptance. Write-back and done come in the cycle after the response handshake. A fault is reported one cycle after acceptance. Cycle counts never depend on loaded data.
- R10: Reset returns the unit to idle: instruction port ready, no request, no response ready, no write, no done, no fault flags. This holds even when reset comes mid-load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| feat_en | input | 1 | Feature enable, sampled with the instruction |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit idle and able to accept |
| instr_word | input | 32 | Instruction encoding |
| rf_rd_idx | output | 5 | Base register read index |
| rf_rd_data | input | 64 | Base register value (combinational read) |
| sp_value | input | 64 | Current stack pointer |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Byte address of the read |
| mem_req_size | output | 3 | Log2 of access size in bytes |
| mem_req_acquire | output | 1 | Acquire ordering qualifier |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Unit waiting for read data |
| mem_rsp_data | input | 64 | Read data, word in low 32 bits |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | 5 | Register write index |
| rf_wr_data | output | 64 | Sign-extended load result |
| done | output | 1 | One-cycle completion pulse |
| undef_flag | output | 1 | Undefined instruction, valid with done |
| align_fault | output | 1 | Stack-pointer misalignment, valid with done |

## Verification
The request is due on the first edge after acceptance, a fault on that same edge, and write-back on the edge after the response handshake. For a load with S request stalls and L response wait cycles, done therefore lands exactly 3+S+L edges after acceptance. The bench counts rising edges and samples every output on the falling edge between them. It records the edge number at acceptance, at the first request and at the response handshake, and compares those numbers against the expected gaps. The check does not wait for an event. Different data values run with the same stall pattern, so any data-dependent timing would show up as a wrong gap.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  localparam int INSN_W = 32;
  localparam int IDX_W  = 5;
  localparam int IMM_W  = 9;
  localparam int SP_IDX = 31;
  localparam logic [10:0] OPC_HI  = 11'b10011001100;
  localparam logic [1:0]  OPC_MID = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC,
    ST_REQ,
    ST_WAIT,
    ST_WB,
    ST_FAULT
  } st_t;

  typedef struct packed {
    logic             hit;
    logic [IMM_W-1:0] imm;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rt;
  } dec_t;
endpackage

// File: rtl/lsw_decode.sv
module lsw_decode
  import lsw_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  logic              feat,
  output dec_t              dec,
  output logic              undef
);
  always_comb begin
    dec.hit = (insn[31:21] == OPC_HI) && (insn[11:10] == OPC_MID);
    dec.imm = insn[20:12];
    dec.rn  = insn[9:5];
    dec.rt  = insn[4:0];
    undef   = !dec.hit || !feat;
  end
endmodule

// File: rtl/lsw_agen.sv
module lsw_agen
  import lsw_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int ALIGN_LOG2 = 4
) (
  input  logic [IDX_W-1:0] rn,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  gpr,
  input  logic [XLEN-1:0]  sp,
  output logic [XLEN-1:0]  addr,
  output logic             misalign
);
  localparam int EXT_W = XLEN - IMM_W;

  logic            use_sp;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] off;

  assign use_sp = (rn == IDX_W'(SP_IDX));
  assign base   = use_sp ? sp : gpr;
  assign off    = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign addr   = base + off;

  generate
    if (ALIGN_LOG2 > 0) begin : g_align
      assign misalign = use_sp && (sp[ALIGN_LOG2-1:0] != '0);
    end else begin : g_noalign
      assign misalign = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/lsw_sext.sv
module lsw_sext #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 64
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  generate
    if (OUT_W > IN_W) begin : g_ext
      assign dout = {{(OUT_W-IN_W){din[IN_W-1]}}, din};
    end else begin : g_pass
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/lsw_ctrl.sv
module lsw_ctrl
  import lsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic instr_valid,
  input  logic chk_fail,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  output logic instr_ready,
  output logic cap_insn,
  output logic cap_chk,
  output logic cap_data,
  output logic req_valid,
  output logic rsp_ready,
  output logic wr_en,
  output logic in_fault,
  output logic done
);
  st_t state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (instr_valid)   state_d = ST_DEC;
      ST_DEC:   state_d = chk_fail ? ST_FAULT : ST_REQ;
      ST_REQ:   if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_d = ST_WB;
      ST_WB:    state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign instr_ready = (state_q == ST_IDLE);
  assign cap_insn    = instr_ready && instr_valid;
  assign cap_chk     = (state_q == ST_DEC);
  assign req_valid   = (state_q == ST_REQ);
  assign rsp_ready   = (state_q == ST_WAIT);
  assign cap_data    = rsp_ready && mem_rsp_valid;
  assign wr_en       = (state_q == ST_WB);
  assign in_fault    = (state_q == ST_FAULT);
  assign done        = wr_en || in_fault;
endmodule

// File: rtl/acq_sword_load_unit.sv
module acq_sword_load_unit
  import lsw_pkg::*;
#(
  parameter int XLEN          = 64,
  parameter int LOAD_BYTES    = 4,
  parameter int SP_ALIGN_LOG2 = 4,
  parameter int RSP_W         = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             feat_en,
  input  logic             instr_valid,
  output logic             instr_ready,
  input  logic [31:0]      instr_word,
  output logic [4:0]       rf_rd_idx,
  input  logic [XLEN-1:0]  rf_rd_data,
  input  logic [XLEN-1:0]  sp_value,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [XLEN-1:0]  mem_req_addr,
  output logic [2:0]       mem_req_size,
  output logic             mem_req_acquire,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [RSP_W-1:0] mem_rsp_data,
  output logic             rf_wr_en,
  output logic [4:0]       rf_wr_idx,
  output logic [XLEN-1:0]  rf_wr_data,
  output logic             done,
  output logic             undef_flag,
  output logic             align_fault
);
  localparam int WORD_W    = LOAD_BYTES * 8;
  localparam int SIZE_CODE = $clog2(LOAD_BYTES);

  logic [INSN_W-1:0] insn_q;
  logic              feat_q;
  dec_t              dec;
  logic              undef_c, mis_c;
  logic [XLEN-1:0]   addr_c, addr_q, ext_c, data_q;
  logic              undef_q, align_q;
  logic              cap_insn, cap_chk, cap_data, in_fault;
  logic              unused_rsp_hi;

  generate
    if (RSP_W > WORD_W) begin : g_hi
      assign unused_rsp_hi = ^mem_rsp_data[RSP_W-1:WORD_W];
    end else begin : g_nohi
      assign unused_rsp_hi = 1'b0;
    end
  endgenerate

  lsw_decode u_dec (
    .insn  (insn_q),
    .feat  (feat_q),
    .dec   (dec),
    .undef (undef_c)
  );

  lsw_agen #(.XLEN(XLEN), .ALIGN_LOG2(SP_ALIGN_LOG2)) u_agen (
    .rn       (dec.rn),
    .imm      (dec.imm),
    .gpr      (rf_rd_data),
    .sp       (sp_value),
    .addr     (addr_c),
    .misalign (mis_c)
  );

  lsw_sext #(.IN_W(WORD_W), .OUT_W(XLEN)) u_sext (
    .din  (mem_rsp_data[WORD_W-1:0]),
    .dout (ext_c)
  );

  lsw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .chk_fail      (undef_c || mis_c),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .instr_ready   (instr_ready),
    .cap_insn      (cap_insn),
    .cap_chk       (cap_chk),
    .cap_data      (cap_data),
    .req_valid     (mem_req_valid),
    .rsp_ready     (mem_rsp_ready),
    .wr_en         (rf_wr_en),
    .in_fault      (in_fault),
    .done          (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insn_q  <= '0;
      feat_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      undef_q <= 1'b0;
      align_q <= 1'b0;
    end else begin
      if (cap_insn) begin
        insn_q <= instr_word;
        feat_q <= feat_en;
      end
      if (cap_chk) begin
        addr_q  <= addr_c;
        undef_q <= undef_c;
        align_q <= !undef_c && mis_c;
      end
      if (cap_data) data_q <= ext_c;
    end
  end

  assign rf_rd_idx       = dec.rn;
  assign mem_req_addr    = addr_q;
  assign mem_req_size    = 3'(SIZE_CODE);
  assign mem_req_acquire = mem_req_valid;
  assign rf_wr_idx       = dec.rt;
  assign rf_wr_data      = data_q;
  assign undef_flag      = in_fault && undef_q;
  assign align_fault     = in_fault && align_q;
endmodule

// File: rtl/lsw_checker.sv
module lsw_checker #(
  parameter int XLEN  = 64,
  parameter int RSP_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [XLEN-1:0]  mem_req_addr,
  input logic [2:0]       mem_req_size,
  input logic             mem_req_acquire,
  input logic             mem_rsp_valid,
  input logic             mem_rsp_ready,
  input logic [RSP_W-1:0] mem_rsp_data,
  input logic             rf_wr_en,
  input logic [XLEN-1:0]  rf_wr_data,
  input logic             done,
  input logic             undef_flag,
  input logic             align_fault
);
  AST_REQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_acquire && mem_req_size == 3'd2)); // R6

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R6

  AST_RSP_TO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_ready) |=> (rf_wr_en && done)); // R9

  AST_WRITE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_ready) |=> (rf_wr_data[31:0] == $past(mem_rsp_data[31:0]))); // R7

  AST_WRITE_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (rf_wr_data[XLEN-1:32] == {(XLEN-32){rf_wr_data[31]}})); // R7

  AST_FAULT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_flag || align_fault) |-> (done && !rf_wr_en && !mem_req_valid)); // R5

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef_flag, align_fault, rf_wr_en})); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || mem_rsp_ready || done) |-> !instr_ready); // R8
endmodule

bind acq_sword_load_unit lsw_checker #(.XLEN(XLEN), .RSP_W(RSP_W)) u_lsw_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .instr_ready     (instr_ready),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_req_addr    (mem_req_addr),
  .mem_req_size    (mem_req_size),
  .mem_req_acquire (mem_req_acquire),
  .mem_rsp_valid   (mem_rsp_valid),
  .mem_rsp_ready   (mem_rsp_ready),
  .mem_rsp_data    (mem_rsp_data),
  .rf_wr_en        (rf_wr_en),
  .rf_wr_data      (rf_wr_data),
  .done            (done),
  .undef_flag      (undef_flag),
  .align_fault     (align_fault)
);

// File: tb/tb_acq_sword_load_unit.sv
`timescale 1ns/1ps
module tb_acq_sword_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        feat_en = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_word = '0;
  logic [4:0]  rf_rd_idx;
  logic [63:0] rf_rd_data;
  logic [63:0] sp_value = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [2:0]  mem_req_size;
  logic        mem_req_acquire;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic        rf_wr_en;
  logic [4:0]  rf_wr_idx;
  logic [63:0] rf_wr_data;
  logic        done;
  logic        undef_flag;
  logic        align_fault;

  logic [63:0] gpr [32];
  assign rf_rd_data = gpr[rf_rd_idx];

  acq_sword_load_unit dut (.*);

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // stimulus table: mode 0 = legal encoding, 1 = bit 22 flipped, 2 = bits [11:10] = 01
  typedef struct packed {
    logic [8:0]  imm;
    logic [4:0]  rn;
    logic [4:0]  rt;
    logic [63:0] base;
    logic        feat;
    logic [1:0]  mode;
    logic [63:0] rsp;
    logic [3:0]  stall;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{9'h010, 5'd3,  5'd7,  64'h0000_0000_0000_1000, 1'b1, 2'd0, 64'hFFFF_FFFF_8000_0001, 4'd0, 4'd0},
    '{9'h100, 5'd0,  5'd0,  64'h0000_0000_0000_0100, 1'b1, 2'd0, 64'h1234_5678_7FFF_FFFF, 4'd2, 4'd3},
    '{9'h0FF, 5'd31, 5'd31, 64'h0000_0000_0000_2000, 1'b1, 2'd0, 64'h0000_0000_9ABC_DEF0, 4'd1, 4'd1},
    '{9'h1FF, 5'd5,  5'd30, 64'h0000_0000_0000_0000, 1'b1, 2'd0, 64'hABCD_0000_FFFF_FFFF, 4'd0, 4'd5},
    '{9'h000, 5'd31, 5'd2,  64'h0000_0000_0000_2008, 1'b1, 2'd0, 64'h0000_0000_1111_1111, 4'd0, 4'd0},
    '{9'h004, 5'd4,  5'd9,  64'h0000_0000_0000_4000, 1'b0, 2'd0, 64'h0000_0000_2222_2222, 4'd0, 4'd0},
    '{9'h004, 5'd4,  5'd9,  64'h0000_0000_0000_4000, 1'b1, 2'd1, 64'h0000_0000_3333_3333, 4'd0, 4'd0},
    '{9'h004, 5'd4,  5'd9,  64'h0000_0000_0000_4000, 1'b1, 2'd2, 64'h0000_0000_4444_4444, 4'd0, 4'd0},
    '{9'h003, 5'd12, 5'd1,  64'hFFFF_FFFF_FFFF_FFFD, 1'b1, 2'd0, 64'hFFFF_FFFF_0000_0000, 4'd2, 4'd3},
    '{9'h0F0, 5'd31, 5'd6,  64'h0000_0000_0000_0010, 1'b0, 2'd1, 64'h0000_0000_5555_5555, 4'd0, 4'd0}
  };

  logic        r_saw_req, r_req_acq, r_stable_ok, r_busy_ready, r_got_done;
  logic        r_wr_en, r_undef, r_align, r_done_after, r_ready_after;
  logic [63:0] r_req_addr, r_wr_data;
  logic [2:0]  r_req_size;
  logic [4:0]  r_wr_idx;
  int          r_acc_cyc, r_req_cyc, r_rsp_cyc, r_done_cyc;

  task automatic run_load(input logic [31:0] iw, input logic fe, input logic [63:0] rspd,
                          input int stall, input int lat);
    int  stall_cnt = 0;
    int  wait_cnt  = 0;
    bit  req_done  = 0;
    bit  rsp_sent  = 0;
    bit  xfer      = 0;
    r_saw_req = 0; r_req_acq = 0; r_stable_ok = 1; r_busy_ready = 0; r_got_done = 0;
    r_wr_en = 0; r_undef = 0; r_align = 0; r_req_addr = '0; r_req_size = '0;
    r_wr_data = '0; r_wr_idx = '0; r_req_cyc = -1; r_rsp_cyc = -1; r_done_cyc = -1;
    @(negedge clk);
    instr_word  = iw;
    feat_en     = fe;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    instr_word  = 32'hFFFF_FFFF;
    feat_en     = ~fe;
    r_acc_cyc   = cyc;
    for (int i = 0; i < 60; i++) begin
      if (xfer) begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        xfer      = 0;
        r_rsp_cyc = cyc;
      end
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        req_done      = 1;
      end else if (mem_req_valid) begin
        if (!r_saw_req) begin
          r_saw_req  = 1;
          r_req_addr = mem_req_addr;
          r_req_size = mem_req_size;
          r_req_acq  = mem_req_acquire;
          r_req_cyc  = cyc;
        end else if (mem_req_addr != r_req_addr || !mem_req_acquire) begin
          r_stable_ok = 0;
        end
        if (stall_cnt < stall) stall_cnt++;
        else mem_req_ready = 1'b1;
      end
      if (instr_ready && !done) r_busy_ready = 1;
      if (req_done && !rsp_sent) begin
        if (wait_cnt < lat) wait_cnt++;
        else begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rspd;
          rsp_sent      = 1;
        end
      end
      if (mem_rsp_valid && mem_rsp_ready) xfer = 1;
      if (done) begin
        r_got_done = 1;
        r_done_cyc = cyc;
        r_wr_en    = rf_wr_en;
        r_wr_idx   = rf_wr_idx;
        r_wr_data  = rf_wr_data;
        r_undef    = undef_flag;
        r_align    = align_fault;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    r_done_after  = done;
    r_ready_after = instr_ready;
    feat_en = 1'b0;
  endtask

  function automatic logic [31:0] mk_insn(input vec_t v);
    logic [31:0] w;
    w = {11'b10011001100, v.imm, 2'b00, v.rn, v.rt};
    if (v.mode == 2'd1) w[22] = ~w[22];
    if (v.mode == 2'd2) w[10] = 1'b1;
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int j = 0; j < 32; j++) gpr[j] = 64'hC0DE_0000_0000_0000 | 64'(j);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(instr_ready && !mem_req_valid && !mem_rsp_ready && !rf_wr_en && !done &&
        !undef_flag && !align_fault, "R10", "idle under reset",
        {57'd0, instr_ready, mem_req_valid, mem_rsp_ready, rf_wr_en, done, undef_flag, align_fault},
        64'h40);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      logic [63:0] exp_addr, exp_data;
      bit exp_undef, exp_align;
      v = VEC[k];
      for (int j = 0; j < 32; j++) gpr[j] = 64'hC0DE_0000_0000_0000 | 64'(j);
      if (v.rn != 5'd31) begin
        gpr[v.rn] = v.base;
        sp_value  = 64'h0000_0000_0000_0007;
      end else begin
        sp_value  = v.base;
      end
      exp_addr  = v.base + {{55{v.imm[8]}}, v.imm};
      exp_data  = {{32{v.rsp[31]}}, v.rsp[31:0]};
      exp_undef = (v.mode != 2'd0) || !v.feat;
      exp_align = !exp_undef && (v.rn == 5'd31) && (v.base[3:0] != 4'd0);
      run_load(mk_insn(v), v.feat, v.rsp, int'(v.stall), int'(v.lat));
      chk(r_got_done, "R8", "done seen", {63'd0, r_got_done}, 64'd1);
      chk(!r_done_after && r_ready_after, "R8", "done one cycle then ready",
          {62'd0, r_done_after, r_ready_after}, 64'd1);
      chk(!r_busy_ready, "R8", "not ready while busy", {63'd0, r_busy_ready}, 64'd0);
      if (exp_undef || exp_align) begin
        chk(r_undef == exp_undef, "R1 R2", "undef flag", {63'd0, r_undef}, {63'd0, exp_undef});
        chk(r_align == exp_align, "R5", "align flag", {63'd0, r_align}, {63'd0, exp_align});
        chk(!r_saw_req && !r_wr_en, "R1 R2 R5", "no request no write",
            {62'd0, r_saw_req, r_wr_en}, 64'd0);
        chk(r_done_cyc - r_acc_cyc == 1, "R9", "fault latency",
            64'(r_done_cyc - r_acc_cyc), 64'd1);
      end else begin
        chk(!r_undef && !r_align, "R1 R5", "no fault flag", {62'd0, r_undef, r_align}, 64'd0);
        chk(r_req_addr == exp_addr, "R3 R4", "request address", r_req_addr, exp_addr);
        chk(r_req_size == 3'd2 && r_req_acq, "R6", "size and acquire",
            {60'd0, r_req_acq, r_req_size}, 64'hA);
        chk(r_stable_ok, "R6", "request held during stall", {63'd0, r_stable_ok}, 64'd1);
        chk(r_wr_en && r_wr_data == exp_data, "R7", "write data", r_wr_data, exp_data);
        chk(r_wr_idx == v.rt, "R7", "write index", {59'd0, r_wr_idx}, {59'd0, v.rt});
        chk(r_req_cyc - r_acc_cyc == 1, "R9", "request latency",
            64'(r_req_cyc - r_acc_cyc), 64'd1);
        chk(r_done_cyc == r_rsp_cyc, "R9", "write after response",
            64'(r_done_cyc - r_rsp_cyc), 64'd0);
        chk(r_done_cyc - r_acc_cyc == 3 + int'(v.stall) + int'(v.lat), "R9", "total latency",
            64'(r_done_cyc - r_acc_cyc), 64'(3 + int'(v.stall) + int'(v.lat)));
      end
    end

    // R10: reset while a request is outstanding
    gpr[3] = 64'h0000_0000_0000_5000;
    sp_value = 64'h0;
    @(negedge clk);
    instr_word  = {11'b10011001100, 9'h008, 2'b00, 5'd3, 5'd4};
    feat_en     = 1'b1;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(mem_req_valid, "R6", "request held without ready", {63'd0, mem_req_valid}, 64'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!mem_req_valid && instr_ready && !done && !rf_wr_en, "R10", "idle after mid-load reset",
        {60'd0, mem_req_valid, instr_ready, done, rf_wr_en}, 64'h4);
    rst_n = 1'b1;
    @(negedge clk);
    run_load({11'b10011001100, 9'h1F0, 2'b00, 5'd3, 5'd4}, 1'b1, 64'h0000_0000_0000_0042, 0, 0);
    chk(r_req_addr == 64'h0000_0000_0000_4FF0, "R3", "address after reset",
        r_req_addr, 64'h4FF0);
    chk(r_wr_data == 64'h42 && r_wr_idx == 5'd4, "R7", "positive word after reset",
        r_wr_data, 64'h42);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule